// File: doc/BRIEF.md
# Synchronous Serial Position Reader

This block is the controller end of a clocked serial link to an absolute position sensor. While idle it holds the serial clock high. When asked for a reading it drives a burst of clock pulses. The sensor presents one bit on each rising edge, and the block samples each bit just before the next falling edge, after the line has had half a clock period to settle. Once the word is complete it checks the bit that must follow the word and then reports the word together with a set of error flags.

The half-period length, the word length and the minimum quiet time between reads are runtime inputs. The quiet time lets the sensor's own update timeout expire, so that every read returns a fresh value. In double-read mode the clock keeps running after the first word, so the sensor sends the same word a second time. The block compares the two copies and reports whether they differ. If the data line is already low when a read is requested, the block does not clock the sensor at all and reports a broken wire.

Top module: `ssi_read_master`

## Requirements
- R1: Whenever `busy` is low, `ssi_clk` is high. After reset `ssi_clk` is high, `pos_valid` is low and `busy` is high.
- R2: `busy` stays high from reset, and from each `pos_valid` pulse, until exactly `cfg_gap` cycles have passed with the clock high. A `req` seen while `busy` is high is ignored: the clock does not fall and no result is produced.
- R3: While reading, the clock alternates between a low half and a high half, each exactly `cfg_half` cycles long (`cfg_half` >= 1). The first half of a read is low.
- R4: In a single read (`cfg_double`=0) the clock has exactly `cfg_nbits`+1 low halves. The first `cfg_nbits` samples, most significant first, appear right-aligned in `pos_word`, with the bits above `cfg_nbits` cleared. `cfg_nbits` ranges from 1 to WORD_W.
- R5: Sample `cfg_nbits`+1 of each frame must be 0. If it is 1 in any frame, `line_fault` is 1 in the result.
- R6: In a double read (`cfg_double`=1) the clock has exactly 2*(`cfg_nbits`+1) low halves with no pause between frames. `pos_word` holds the first copy, and `mismatch` is 1 exactly when the two copies differ.
- R7: If `ssi_data` is 0 when a request is accepted, the clock does not fall. The result has `broken_wire`=1, `pos_word`=0, `line_fault`=0 and `mismatch`=0.
- R8: `pos_valid` is a single-cycle pulse. `pos_word` and the three flags change only together with it and hold their values between results. Only `broken_wire` results have `broken_wire`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 1 | Read request, taken when `busy` is low |
| cfg_half | input | HALF_W | Half-period of the serial clock in system cycles |
| cfg_nbits | input | CNT_W | Word length in bits |
| cfg_gap | input | GAP_W | Minimum clock-high cycles between reads |
| cfg_double | input | 1 | Read the word twice and compare the copies |
| ssi_data | input | 1 | Serial data from the sensor |
| ssi_clk | output | 1 | Serial clock to the sensor |
| busy | output | 1 | Read in progress or quiet time not yet over |
| pos_word | output | WORD_W | Last word read |
| pos_valid | output | 1 | One-cycle result strobe |
| line_fault | output | 1 | Trailing bit was found high |
| mismatch | output | 1 | The two copies of a double read differed |
| broken_wire | output | 1 | Data line was low before the read |

## Verification
The hardest case to reach is a double read that shows a fault only in the second copy, such as a corrupted first bit or a trailing bit stuck high. It needs a sensor that keeps following a clock running without a pause across the frame boundary. The bench models the sensor as a process that watches `ssi_clk`, counts rising edges modulo the frame length, and on command flips the first bit of the second copy or holds the trailing bit high. The quiet-time rule is reached by issuing a request right after a result, while the sensor's timeout is still running.

// File: rtl/ssi_rd_pkg.sv
package ssi_rd_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOW  = 2'd1,
        ST_HIGH = 2'd2
    } ssi_state_e;
endpackage

// File: rtl/ssi_half_timer.sv
module ssi_half_timer #(
    parameter int HALF_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [HALF_W-1:0] half,
    output logic              expire
);
    logic [HALF_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = (half == '0) ? '0 : half - 1'b1;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expire = (cnt_q == '0);
endmodule

// File: rtl/ssi_gap_timer.sv
module ssi_gap_timer #(
    parameter int GAP_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic [GAP_W-1:0] limit,
    output logic             done
);
    localparam logic [GAP_W-1:0] CNT_MAX = '1;
    logic [GAP_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear)                cnt_d = '0;
        else if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign done = (cnt_q >= limit);
endmodule

// File: rtl/ssi_frame_shift.sv
module ssi_frame_shift #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              shift,
    input  logic              save,
    input  logic              bit_in,
    output logic [WORD_W-1:0] word,
    output logic [WORD_W-1:0] first
);
    logic [WORD_W-1:0] sh_d, sh_q, first_d, first_q;

    always_comb begin
        sh_d    = sh_q;
        first_d = first_q;
        if (save)       first_d = sh_q;
        if (clear)      sh_d = '0;
        else if (shift) sh_d = {sh_q[WORD_W-2:0], bit_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q    <= '0;
            first_q <= '0;
        end else begin
            sh_q    <= sh_d;
            first_q <= first_d;
        end
    end

    assign word  = sh_q;
    assign first = first_q;
endmodule

// File: rtl/ssi_read_master.sv
module ssi_read_master
    import ssi_rd_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int HALF_W = 12,
    parameter int GAP_W  = 16,
    localparam int CNT_W = $clog2(WORD_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [HALF_W-1:0] cfg_half,
    input  logic [CNT_W-1:0]  cfg_nbits,
    input  logic [GAP_W-1:0]  cfg_gap,
    input  logic              cfg_double,
    input  logic              ssi_data,
    output logic              ssi_clk,
    output logic              busy,
    output logic [WORD_W-1:0] pos_word,
    output logic              pos_valid,
    output logic              line_fault,
    output logic              mismatch,
    output logic              broken_wire
);
    typedef struct packed {
        ssi_state_e        state;
        logic [CNT_W-1:0]  bit_cnt;
        logic [CNT_W-1:0]  nbits;
        logic              dbl;
        logic              frame;
        logic              lf_acc;
        logic              sclk;
        logic [WORD_W-1:0] word_out;
        logic              valid;
        logic              lf_out;
        logic              mm_out;
        logic              bw_out;
    } ctrl_t;

    localparam ctrl_t CTRL_RST = '{
        state:    ST_IDLE,
        bit_cnt:  '0,
        nbits:    '0,
        dbl:      1'b0,
        frame:    1'b0,
        lf_acc:   1'b0,
        sclk:     1'b1,
        word_out: '0,
        valid:    1'b0,
        lf_out:   1'b0,
        mm_out:   1'b0,
        bw_out:   1'b0
    };

    ctrl_t r_d, r_q;

    logic              t_load, t_expire;
    logic              g_clear, g_done;
    logic              sh_clear, sh_shift, sh_save;
    logic [WORD_W-1:0] sh_word, sh_first;
    logic              lf_now;

    ssi_half_timer #(.HALF_W(HALF_W)) u_half (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (t_load),
        .half   (cfg_half),
        .expire (t_expire)
    );

    ssi_gap_timer #(.GAP_W(GAP_W)) u_gap (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (g_clear),
        .limit (cfg_gap),
        .done  (g_done)
    );

    ssi_frame_shift #(.WORD_W(WORD_W)) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (sh_clear),
        .shift  (sh_shift),
        .save   (sh_save),
        .bit_in (ssi_data),
        .word   (sh_word),
        .first  (sh_first)
    );

    always_comb begin
        r_d      = r_q;
        r_d.valid = 1'b0;
        t_load   = 1'b0;
        g_clear  = 1'b0;
        sh_clear = 1'b0;
        sh_shift = 1'b0;
        sh_save  = 1'b0;
        lf_now   = r_q.lf_acc | ssi_data;

        unique case (r_q.state)
            ST_IDLE: begin
                r_d.sclk = 1'b1;
                if (req && g_done) begin
                    if (!ssi_data) begin
                        // line already low: report without clocking
                        r_d.valid    = 1'b1;
                        r_d.word_out = '0;
                        r_d.lf_out   = 1'b0;
                        r_d.mm_out   = 1'b0;
                        r_d.bw_out   = 1'b1;
                        g_clear      = 1'b1;
                    end else begin
                        r_d.state   = ST_LOW;
                        r_d.sclk    = 1'b0;
                        r_d.bit_cnt = '0;
                        r_d.nbits   = cfg_nbits;
                        r_d.dbl     = cfg_double;
                        r_d.frame   = 1'b0;
                        r_d.lf_acc  = 1'b0;
                        t_load      = 1'b1;
                        sh_clear    = 1'b1;
                    end
                end
            end

            ST_LOW: begin
                if (t_expire) begin
                    r_d.state = ST_HIGH;
                    r_d.sclk  = 1'b1;
                    t_load    = 1'b1;
                end
            end

            ST_HIGH: begin
                if (t_expire) begin
                    if (r_q.bit_cnt < r_q.nbits) begin
                        // data bit: sample, then falling edge
                        sh_shift    = 1'b1;
                        r_d.bit_cnt = r_q.bit_cnt + CNT_W'(1);
                        r_d.state   = ST_LOW;
                        r_d.sclk    = 1'b0;
                        t_load      = 1'b1;
                    end else if (r_q.dbl && !r_q.frame) begin
                        // trailing bit of first copy, keep clocking
                        sh_save     = 1'b1;
                        sh_clear    = 1'b1;
                        r_d.frame   = 1'b1;
                        r_d.bit_cnt = '0;
                        r_d.lf_acc  = lf_now;
                        r_d.state   = ST_LOW;
                        r_d.sclk    = 1'b0;
                        t_load      = 1'b1;
                    end else begin
                        r_d.state    = ST_IDLE;
                        r_d.sclk     = 1'b1;
                        r_d.valid    = 1'b1;
                        r_d.word_out = r_q.dbl ? sh_first : sh_word;
                        r_d.mm_out   = r_q.dbl && (sh_first != sh_word);
                        r_d.lf_out   = lf_now;
                        r_d.bw_out   = 1'b0;
                        g_clear      = 1'b1;
                    end
                end
            end

            default: begin
                r_d = CTRL_RST;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= CTRL_RST;
        else        r_q <= r_d;
    end

    assign ssi_clk     = r_q.sclk;
    assign busy        = !((r_q.state == ST_IDLE) && g_done);
    assign pos_word    = r_q.word_out;
    assign pos_valid   = r_q.valid;
    assign line_fault  = r_q.lf_out;
    assign mismatch    = r_q.mm_out;
    assign broken_wire = r_q.bw_out;
endmodule

// File: rtl/ssi_read_master_chk.sv
module ssi_read_master_chk #(
    parameter int WORD_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req,
    input logic              ssi_data,
    input logic              ssi_clk,
    input logic              busy,
    input logic [WORD_W-1:0] pos_word,
    input logic              pos_valid,
    input logic              line_fault,
    input logic              mismatch,
    input logic              broken_wire
);
    assert_idle_clk_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> ssi_clk);

    assert_low_means_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !ssi_clk |-> busy);

    assert_no_start_without_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !req) |=> ssi_clk);

    assert_no_clock_on_broken_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req && !ssi_data) |=> ssi_clk);

    assert_broken_result_clean_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_valid && broken_wire) |-> (pos_word == '0 && !line_fault && !mismatch));

    assert_valid_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pos_valid |=> !pos_valid);

    assert_word_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !pos_valid |-> ($stable(pos_word) && $stable(line_fault) && $stable(mismatch)
                        && $stable(broken_wire)));
endmodule

bind ssi_read_master ssi_read_master_chk #(.WORD_W(WORD_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req         (req),
    .ssi_data    (ssi_data),
    .ssi_clk     (ssi_clk),
    .busy        (busy),
    .pos_word    (pos_word),
    .pos_valid   (pos_valid),
    .line_fault  (line_fault),
    .mismatch    (mismatch),
    .broken_wire (broken_wire)
);

// File: tb/sim_ssi_read_master.sv
module sim_ssi_read_master;
    localparam int CLK_PERIOD = 10;
    localparam int WORD_W = 32;
    localparam int HALF_W = 12;
    localparam int GAP_W  = 16;
    localparam int CNT_W  = $clog2(WORD_W + 1);
    localparam int SENS_TO = 20;
    localparam int GAP    = 40;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req = 1'b0;
    logic [HALF_W-1:0] cfg_half = 12'd2;
    logic [CNT_W-1:0]  cfg_nbits = CNT_W'(12);
    logic [GAP_W-1:0]  cfg_gap = GAP_W'(GAP);
    logic              cfg_double = 1'b0;
    logic              ssi_data = 1'b1;
    logic              ssi_clk, busy, pos_valid, line_fault, mismatch, broken_wire;
    logic [WORD_W-1:0] pos_word;

    always #(CLK_PERIOD/2) clk = ~clk;

    ssi_read_master #(.WORD_W(WORD_W), .HALF_W(HALF_W), .GAP_W(GAP_W)) u0 (
        .clk(clk), .rst_n(rst_n), .req(req), .cfg_half(cfg_half),
        .cfg_nbits(cfg_nbits), .cfg_gap(cfg_gap), .cfg_double(cfg_double),
        .ssi_data(ssi_data), .ssi_clk(ssi_clk), .busy(busy),
        .pos_word(pos_word), .pos_valid(pos_valid), .line_fault(line_fault),
        .mismatch(mismatch), .broken_wire(broken_wire)
    );

    int total = 0;
    int bad = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- sensor model ----------------
    logic [WORD_W-1:0] sens_word = '0;
    int  sens_n = 12;
    bit  sens_trail_fault = 0;
    bit  sens_corrupt = 0;
    bit  sens_broken = 0;
    bit  s_active = 0;
    bit  s_prev = 1;
    int  s_rises = 0;
    int  s_high = 0;
    logic [WORD_W-1:0] s_word = '0;

    always @(negedge clk) begin
        if (ssi_clk) s_high = s_high + 1;
        if (!s_active && ssi_clk) ssi_data <= !sens_broken;
        if (s_prev && !ssi_clk) begin
            if (!s_active) begin
                s_active = 1;
                s_rises = 0;
                s_word = sens_word;
            end
            s_high = 0;
        end else if (!s_prev && ssi_clk) begin
            int pos, cpy;
            s_rises = s_rises + 1;
            pos = (s_rises - 1) % (sens_n + 1);
            cpy = (s_rises - 1) / (sens_n + 1);
            if (pos < sens_n) begin
                logic b;
                b = s_word[sens_n - 1 - pos];
                if (sens_corrupt && cpy >= 1 && pos == 0) b = ~b;
                ssi_data <= b;
            end else begin
                ssi_data <= sens_trail_fault;
            end
            s_high = 1;
        end
        if (s_active && ssi_clk && s_high > SENS_TO) s_active = 0;
        s_prev = ssi_clk;
    end

    // ---------------- scoreboard ----------------
    typedef struct {
        logic [WORD_W-1:0] w;
        bit lf, mm, bw;
    } exp_t;
    exp_t exp_q[$];
    int done_cnt = 0;

    always @(negedge clk) begin
        if (rst_n && pos_valid) begin
            if (exp_q.size() == 0) begin
                chk(0, "R2 unexpected result", 1, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(pos_word == e.w, "R4 word", pos_word, e.w);
                chk(line_fault == e.lf, "R5 line_fault", line_fault, e.lf);
                chk(mismatch == e.mm, "R6 mismatch", mismatch, e.mm);
                chk(broken_wire == e.bw, "R7 broken_wire", broken_wire, e.bw);
            end
            done_cnt++;
        end
    end

    // low-half length and total low cycles (R3)
    int low_run = 0;
    int low_tot = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (!ssi_clk) begin
                low_run++;
                low_tot++;
            end else if (low_run != 0) begin
                chk(low_run == int'(cfg_half), "R3 low half length", low_run, cfg_half);
                low_run = 0;
            end
        end
    end

    // high-half length inside a read (R3)
    int high_run = 0;
    bit seen_low = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (!ssi_clk) begin
                if (seen_low && high_run != 0)
                    chk(high_run == int'(cfg_half), "R3 high half length", high_run, cfg_half);
                seen_low = 1;
                high_run = 0;
            end else if (seen_low) begin
                high_run++;
                if (pos_valid) begin
                    seen_low = 0;
                    high_run = 0;
                end
            end
        end
    end

    // quiet time after each result (R2)
    int g_cnt = 0;
    bit g_meas = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (pos_valid) begin
                chk(busy == 1'b1, "R2 busy after result", busy, 1);
                g_cnt = 1;
                g_meas = 1;
            end else if (g_meas && busy) begin
                g_cnt++;
            end else if (g_meas) begin
                chk(g_cnt == GAP, "R2 quiet cycles", g_cnt, GAP);
                g_meas = 0;
            end
        end
    end

    // R1: clock high whenever not busy
    always @(negedge clk) begin
        if (rst_n && !busy && !ssi_clk) chk(0, "R1 clock low while idle", 0, 1);
    end

    task automatic do_read(input logic [WORD_W-1:0] w, input int n, input int half,
                           input bit dbl, input bit tf, input bit cor, input bit brk);
        exp_t e;
        int d0, exp_low;
        logic [63:0] mask;
        while (busy) @(negedge clk);
        cfg_half = HALF_W'(half);
        cfg_nbits = CNT_W'(n);
        cfg_double = dbl;
        sens_word = w;
        sens_n = n;
        sens_trail_fault = tf;
        sens_corrupt = cor;
        sens_broken = brk;
        @(negedge clk);
        @(negedge clk);
        mask = (64'd1 << n) - 64'd1;
        e.w = brk ? '0 : WORD_W'(64'(w) & mask);
        e.lf = brk ? 1'b0 : tf;
        e.mm = brk ? 1'b0 : (dbl && cor);
        e.bw = brk;
        exp_q.push_back(e);
        low_tot = 0;
        d0 = done_cnt;
        req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        while (done_cnt == d0) @(negedge clk);
        exp_low = brk ? 0 : (dbl ? 2 * (n + 1) * half : (n + 1) * half);
        if (brk)
            chk(low_tot == 0, "R7 no clock on broken wire", low_tot, 0);
        else if (dbl)
            chk(low_tot == exp_low, "R6 double read low cycles", low_tot, exp_low);
        else
            chk(low_tot == exp_low, "R4 single read low cycles", low_tot, exp_low);
        sens_broken = 0;
    endtask

    int cycles = 0;
    always @(negedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            chk(0, "watchdog R2", cycles, 150000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(ssi_clk == 1'b1, "R1 reset clock", ssi_clk, 1);
        chk(pos_valid == 1'b0, "R1 reset valid", pos_valid, 0);
        chk(busy == 1'b1, "R1 reset busy", busy, 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b1, "R2 busy during startup quiet", busy, 1);

        do_read(32'h0000_0A5C, 12, 2, 0, 0, 0, 0);
        do_read(32'hDEAD_BEEF, 32, 3, 0, 0, 0, 0);
        do_read(32'h0000_0001, 1, 1, 0, 0, 0, 0);
        do_read(32'hFFFF_FF3C, 8, 2, 0, 0, 0, 0);
        do_read(32'h0000_00B3, 8, 2, 0, 1, 0, 0);
        do_read(32'h0000_02D1, 10, 2, 1, 0, 0, 0);
        do_read(32'h0000_02D1, 10, 2, 1, 0, 1, 0);
        do_read(32'h0000_0155, 10, 3, 1, 1, 0, 0);
        do_read(32'h1234_5678, 16, 2, 0, 0, 0, 1);
        do_read(32'h8000_0001, 32, 1, 1, 0, 0, 0);

        // R2: request during quiet time is ignored
        begin
            int d0;
            d0 = done_cnt;
            chk(busy == 1'b1, "R2 busy before ignored req", busy, 1);
            low_tot = 0;
            req = 1'b1;
            @(negedge clk);
            req = 1'b0;
            repeat (10) @(negedge clk);
            chk(low_tot == 0, "R2 ignored req no clock", low_tot, 0);
            chk(done_cnt == d0, "R2 ignored req no result", done_cnt, d0);
        end
        do_read(32'h0000_0777, 12, 1, 0, 0, 0, 0);

        while (busy) @(negedge clk);
        repeat (5) @(negedge clk);
        chk(exp_q.size() == 0, "R8 all results seen", exp_q.size(), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule